// File: doc/BRIEF.md
# PWM Output Modulation and Polarity Stage

This block is the last stage of a three-channel PWM generator. It produces six pin levels, one direct line and one complementary line for each channel. For every line it combines up to three modulation sources, each of which can be switched on or off. The sources are:

- a dead-time-processed compare state from the main timer;
- a compare state from a second timer, shared by all lines;
- one bit of a multi-channel pattern.

A shared trap input can veto any line that has its trap enable set. The result is an active or passive state for each line.

A passive-level bit then turns that state into a pin level. This keeps the question of whether a line is active apart from the polarity the external driver needs. The passive-level bits are double-buffered. Software writes a shadow copy, and the copy goes live only on the main timer's shadow-transfer strobe, so a polarity change never cuts into the middle of a PWM period. A small register port gives write and read access to the enables and polarity bits.

Top module: `pwm_out_mod`

## Requirements
- R1: After reset every enable register, shadow passive-level bit and working passive-level bit reads 0, and all six pins are low.
- R2: A line is active only when every source enabled for it is active. The sources are main compare bit n (enable register 0, bit n), the shared second compare bit (enable register 1, bit n) and pattern bit n (common enable at register 3, bit 0). Any enabled source that is 0 makes the line passive.
- R3: A line with no enabled source is passive, whatever the source values are.
- R4: While trap_i is 1, every line whose bit in register 2 is set is passive. Lines whose trap enable is clear are not affected by trap_i.
- R5: pin_o[n] equals the working passive-level bit n when line n is passive, and its inverse when line n is active.
- R6: A write to register 4 changes only the shadow passive-level bits. The pins and the read value of register 4 stay unchanged until xfer_i is seen high at a clock edge. At that edge the shadow is copied to the working bits.
- R7: A read of register 4 returns the working passive-level bits, not pending shadow values. Registers 0 to 3 read back the value last written.
- R8: When a write to register 4 and xfer_i fall in the same cycle, the newly written value becomes the working value at that edge.
- R9: Line index 2k is the direct output of channel k and line 2k+1 is its complementary output. Bit n of every per-line register and input belongs to line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_cmp_i | input | 6 | Dead-time-processed main compare state per line, 1 = active |
| sec_cmp_i | input | 1 | Second timer compare state, 1 = active |
| pattern_i | input | 6 | Multi-channel pattern, one bit per line |
| trap_i | input | 1 | Trap state, 1 = trap asserted |
| xfer_i | input | 1 | Main timer shadow-transfer strobe, one cycle |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| pin_o | output | 6 | Pin levels |

## Verification
The hardest state to reach from the ports is a pending shadow value that differs from the working one. Only there can a read or a pin reveal whether a write leaked past the transfer strobe. The bench writes inverted polarity bits without a strobe. It then holds the lines in a known state and checks both the pins and the read-back of register 4 before issuing the strobe. It also sets a write and a strobe in the same cycle, so that a design which transfers the old shadow value is exposed. A vector table covers the AND combinations of the sources, the trap veto with and without enables, and the polarity inversion.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;
  parameter int unsigned NCH = 3;
  parameter int unsigned DW  = 8;
  parameter int unsigned AW  = 3;
  localparam int unsigned NLINE = 2 * NCH;

  localparam logic [AW-1:0] A_MAIN_EN = 3'd0;
  localparam logic [AW-1:0] A_SEC_EN  = 3'd1;
  localparam logic [AW-1:0] A_TRAP_EN = 3'd2;
  localparam logic [AW-1:0] A_PAT_EN  = 3'd3;
  localparam logic [AW-1:0] A_PSL     = 3'd4;
endpackage

// File: rtl/pwm_mod_regs.sv
module pwm_mod_regs
  import pwm_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NLINE-1:0] psl_work_i,
  output logic [NLINE-1:0] main_en_o,
  output logic [NLINE-1:0] sec_en_o,
  output logic [NLINE-1:0] trap_en_o,
  output logic             pat_en_o,
  output logic             psl_wr_o,
  output logic [DW-1:0]    rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DW-1:NLINE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_en_o <= '0;
      sec_en_o  <= '0;
      trap_en_o <= '0;
      pat_en_o  <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MAIN_EN: main_en_o <= wdata_i[NLINE-1:0];
        A_SEC_EN:  sec_en_o  <= wdata_i[NLINE-1:0];
        A_TRAP_EN: trap_en_o <= wdata_i[NLINE-1:0];
        A_PAT_EN:  pat_en_o  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign psl_wr_o = wr_en_i && (addr_i == A_PSL);

  // psl reads return working bits, never the shadow
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MAIN_EN: rdata_o[NLINE-1:0] = main_en_o;
      A_SEC_EN:  rdata_o[NLINE-1:0] = sec_en_o;
      A_TRAP_EN: rdata_o[NLINE-1:0] = trap_en_o;
      A_PAT_EN:  rdata_o[0]         = pat_en_o;
      A_PSL:     rdata_o[NLINE-1:0] = psl_work_i;
      default:   rdata_o = '0;
    endcase
  end

  p_wr_main_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MAIN_EN) |=> main_en_o == $past(wdata_i[NLINE-1:0]));
endmodule

// File: rtl/pwm_mod_psl.sv
module pwm_mod_psl
  import pwm_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NLINE-1:0] wdata_i,
  input  logic             xfer_i,
  output logic [NLINE-1:0] work_o
);
  logic [NLINE-1:0] shadow_q;
  logic [NLINE-1:0] shadow_d;

  // a write in the strobe cycle is forwarded straight to the working bits
  assign shadow_d = wr_i ? wdata_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      work_o   <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (xfer_i) work_o <= shadow_d;
    end
  end

  p_psl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(work_o));
  p_psl_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && wr_i) |=> work_o == $past(wdata_i));
endmodule

// File: rtl/pwm_mod_line.sv
module pwm_mod_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_cmp_i,
  input  logic main_en_i,
  input  logic sec_cmp_i,
  input  logic sec_en_i,
  input  logic pat_i,
  input  logic pat_en_i,
  input  logic trap_i,
  input  logic trap_en_i,
  output logic act_o
);
  logic any_en;
  logic all_ok;

  assign any_en = main_en_i | sec_en_i | pat_en_i;
  assign all_ok = (!main_en_i || main_cmp_i) &&
                  (!sec_en_i  || sec_cmp_i)  &&
                  (!pat_en_i  || pat_i);
  assign act_o  = any_en && all_ok && !(trap_i && trap_en_i);

  p_no_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_en_i || sec_en_i || pat_en_i) |-> !act_o);
  p_trap_veto_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && trap_en_i) |-> !act_o);
  p_and_main_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_en_i && !main_cmp_i) |-> !act_o);
  p_and_pat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_en_i && !pat_i) |-> !act_o);
endmodule

// File: rtl/pwm_out_mod.sv
module pwm_out_mod
  import pwm_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] main_cmp_i,
  input  logic             sec_cmp_i,
  input  logic [NLINE-1:0] pattern_i,
  input  logic             trap_i,
  input  logic             xfer_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NLINE-1:0] pin_o
);
  logic [NLINE-1:0] main_en, sec_en, trap_en, psl_work, act;
  logic             pat_en, psl_wr;

  pwm_mod_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .psl_work_i(psl_work),
    .main_en_o(main_en), .sec_en_o(sec_en), .trap_en_o(trap_en),
    .pat_en_o(pat_en), .psl_wr_o(psl_wr), .rdata_o
  );

  pwm_mod_psl i_psl (
    .clk_i, .rst_ni,
    .wr_i(psl_wr), .wdata_i(wdata_i[NLINE-1:0]), .xfer_i,
    .work_o(psl_work)
  );

  // line 2k = direct output of channel k, 2k+1 = its complement
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    for (genvar side = 0; side < 2; side++) begin : g_side
      localparam int unsigned L = 2 * ch + side;
      pwm_mod_line i_line (
        .clk_i, .rst_ni,
        .main_cmp_i(main_cmp_i[L]), .main_en_i(main_en[L]),
        .sec_cmp_i,                 .sec_en_i(sec_en[L]),
        .pat_i(pattern_i[L]),       .pat_en_i(pat_en),
        .trap_i,                    .trap_en_i(trap_en[L]),
        .act_o(act[L])
      );
      assign pin_o[L] = act[L] ^ psl_work[L];
    end
  end

  p_trap_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && (&trap_en)) |-> pin_o == psl_work);
endmodule

// File: tb/test_pwm_out_mod.sv
module test_pwm_out_mod;
  import pwm_mod_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [5:0] main_cmp = '0, pattern = '0;
  logic sec_cmp = 1'b0, trap = 1'b0, xfer = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [5:0] pin;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwm_out_mod i_pwm_out_mod (
    .clk_i(clk), .rst_ni, .main_cmp_i(main_cmp), .sec_cmp_i(sec_cmp),
    .pattern_i(pattern), .trap_i(trap), .xfer_i(xfer), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin)
  );

  typedef struct packed {
    logic [5:0] main_en, sec_en, trap_en;
    logic       pat_en;
    logic [5:0] psl, main, pat;
    logic       sec, trp;
    logic [5:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R3: nothing enabled
    {6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b111111, 6'b111111, 1'b1, 1'b0, 6'b000000},
    // R2/R9: main only
    {6'b111111, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b101010, 6'b000000, 1'b0, 1'b0, 6'b101010},
    // R2: second compare passive vetoes
    {6'b111111, 6'b111111, 6'b000000, 1'b0, 6'b000000, 6'b111111, 6'b000000, 1'b0, 1'b0, 6'b000000},
    // R2: both active
    {6'b111111, 6'b111111, 6'b000000, 1'b0, 6'b000000, 6'b111111, 6'b000000, 1'b1, 1'b0, 6'b111111},
    // R2: pattern with partial main enables
    {6'b000111, 6'b000000, 6'b000000, 1'b1, 6'b000000, 6'b111111, 6'b110011, 1'b0, 1'b0, 6'b110011},
    // R5: polarity
    {6'b111111, 6'b000000, 6'b000000, 1'b0, 6'b010101, 6'b000111, 6'b000000, 1'b0, 1'b0, 6'b010010},
    // R4: trap on enabled lines only
    {6'b111111, 6'b000000, 6'b001111, 1'b0, 6'b000000, 6'b111111, 6'b000000, 1'b0, 1'b1, 6'b110000},
    // R4/R5: trap all, pins at passive level
    {6'b111111, 6'b000000, 6'b111111, 1'b0, 6'b100001, 6'b111111, 6'b000000, 1'b0, 1'b1, 6'b100001},
    // R4: trap without enables has no effect
    {6'b111111, 6'b000000, 6'b000000, 1'b0, 6'b000011, 6'b011110, 6'b000000, 1'b0, 1'b1, 6'b011101}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic strobe);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; xfer = strobe;
    @(negedge clk);
    wr_en = 1'b0; xfer = 1'b0;
  endtask

  task automatic strobe_only();
    @(negedge clk); xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    main_cmp = '1; pattern = '1; sec_cmp = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 pins", {2'b0, pin}, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], r);
      chk("R1 reg", r, 8'h00);
    end

    for (int i = 0; i < NV; i++) begin
      wr(A_MAIN_EN, {2'b0, VECS[i].main_en}, 1'b0);
      wr(A_SEC_EN,  {2'b0, VECS[i].sec_en}, 1'b0);
      wr(A_TRAP_EN, {2'b0, VECS[i].trap_en}, 1'b0);
      wr(A_PAT_EN,  {7'b0, VECS[i].pat_en}, 1'b0);
      wr(A_PSL,     {2'b0, VECS[i].psl}, 1'b1);
      @(negedge clk);
      main_cmp = VECS[i].main; pattern = VECS[i].pat;
      sec_cmp = VECS[i].sec; trap = VECS[i].trp;
      #1;
      chk($sformatf("R2/R3/R4/R5 vec %0d", i), {2'b0, pin}, {2'b0, VECS[i].exp});
    end

    // R7/R9 readback of enables
    wr(A_SEC_EN, 8'h2d, 1'b0);
    rd(A_SEC_EN, r);
    chk("R7 sec_en readback", r, 8'h2d);
    wr(A_PAT_EN, 8'h01, 1'b0);
    rd(A_PAT_EN, r);
    chk("R7 pat_en readback", r, 8'h01);

    // set a known state: all lines active, no trap, psl 0
    wr(A_MAIN_EN, 8'h3f, 1'b0);
    wr(A_SEC_EN, 8'h00, 1'b0);
    wr(A_PAT_EN, 8'h00, 1'b0);
    wr(A_TRAP_EN, 8'h00, 1'b0);
    trap = 1'b0; main_cmp = 6'b111111;
    wr(A_PSL, 8'h00, 1'b1);
    @(negedge clk);
    chk("R5 active, psl 0", {2'b0, pin}, 8'h3f);

    // R6: shadow write without strobe does not take effect
    wr(A_PSL, 8'h15, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 pins hold", {2'b0, pin}, 8'h3f);
    rd(A_PSL, r);
    chk("R7 read returns working", r, 8'h00);
    strobe_only();
    chk("R6 pins after strobe", {2'b0, pin}, 8'h2a);
    rd(A_PSL, r);
    chk("R6 read after strobe", r, 8'h15);

    // R8: write and strobe together
    wr(A_PSL, 8'h30, 1'b1);
    chk("R8 same-cycle pins", {2'b0, pin}, 8'h0f);
    rd(A_PSL, r);
    chk("R8 same-cycle read", r, 8'h30);

    // R6: strobe with nothing pending keeps value
    strobe_only();
    rd(A_PSL, r);
    chk("R6 repeat strobe", r, 8'h30);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_ni = 1'b0;
    #1;
    chk("R1 pins after reset", {2'b0, pin}, 8'h00);
    rd(A_MAIN_EN, r);
    chk("R1 main_en after reset", r, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    strobe_only();
    rd(A_PSL, r);
    chk("R1 shadow cleared", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule